// File: doc/BRIEF.md
# Frame Buffer Fetch Address Generator

This block produces the stream of word addresses that a display DMA engine reads to refresh a panel from a frame buffer in memory. Software sets the region nibble, the line length, the buffer size and the pixel depth through a small write-only register port, then sets the enable bit. While enabled, the block offers one 32-bit read address per word in raster order over a valid/ready handshake. It flags the last word of each display line and the last word of the buffer, and then starts the next frame at offset zero.

The buffer always begins at offset zero inside the selected region. The region nibble becomes bits 31:28 of every address, and the word offset sits at bits 16:2. The hardware refuses settings that would corrupt an ongoing fetch or land on reserved regions. Every refused write leaves the stored setting unchanged and raises a sticky error flag.

Register select codes on `cfg_sel`: 0 control, 1 region nibble, 2 line length, 3 buffer size.

Top module: `fbuf_addr_gen`

## Requirements
- R1: After reset `req_valid` and `cfg_err` are low, and the configuration is region 0xC, 64 line units, depth code 2 and 32768 buffer words. Enabling without other writes therefore starts at address 0xC000_0000 with 128 words per line.
- R2: On enable the offset starts at zero. `req_addr` equals {region nibble, eleven zero bits, word offset, 2'b00}, and each accepted request raises it by 4.
- R3: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_line_end` and `req_frame_end` hold their values and the offset does not advance.
- R4: A line holds ceil(units x bpp / 2) words. Units is `cfg_wdata[6:0]` of a line write (16 pixels each). bpp is 1, 2 or 4 for control depth code (`cfg_wdata[2:1]`) 0, 1 or 2. `req_line_end` is high with the last word of each line.
- R5: A buffer-size write stores `cfg_wdata[14:0]` as the word count minus one. `req_frame_end` is high with the word at that offset. The next word is at offset zero, and the line word count restarts there.
- R6: While enabled, a write to the region, line or size register changes nothing and sets `cfg_err`. A control write changes only the enable bit (`cfg_wdata[0]`), and its depth field is ignored.
- R7: A region write of 0x7 or 0x8, a line write outside 2..64, or a control write with depth code 3 (while disabled) is rejected as a whole and sets `cfg_err`. Writes of 0x6 and 64 are accepted.
- R8: A control write clearing the enable bit drops `req_valid` after that clock edge. A later enable restarts at offset zero.
- R9: `cfg_err` stays high until reset once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_err | output | 1 | Sticky refused-write flag |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Word-aligned read address |
| req_line_end | output | 1 | Request is the last word of a line |
| req_frame_end | output | 1 | Request is the last word of the buffer |

## Verification
The stepping and wrap properties assume that no register write lands in the same cycle as an accepted request. A control write in that cycle could disable the block, so those properties are qualified with the write strobe. The hold property assumes the consumer keeps `req_ready` low until it can take the word.

The stimulus performs every register write with `req_ready` low. It toggles `req_ready` only between writes, using fixed patterns that include both long stalls and back-to-back acceptance. A scoreboard predicts each address and its markers from the written settings alone.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  localparam int BASE_W = 4;
  localparam logic [BASE_W-1:0] BASE_RST    = 4'hC;
  localparam logic [BASE_W-1:0] BASE_RESV_A = 4'h7;
  localparam logic [BASE_W-1:0] BASE_RESV_B = 4'h8;
  localparam logic [1:0] DEPTH_RST = 2'd2;
  localparam logic [1:0] DEPTH_BAD = 2'd3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_LINE = 2'd2,
    SEL_SIZE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fbag_cfg.sv
module fbag_cfg
  import fbag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int UNIT_W   = 7,
  parameter int OFF_W    = 15,
  parameter int UNIT_MIN = 2,
  parameter int UNIT_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic [1:0]        depth,
  output logic [BASE_W-1:0] base,
  output logic [UNIT_W-1:0] units,
  output logic [OFF_W-1:0]  size_m1,
  output logic              err
);
  logic              en_q, en_n, err_q, err_n;
  logic [1:0]        dep_q, dep_n;
  logic [BASE_W-1:0] base_q, base_n;
  logic [UNIT_W-1:0] unit_q, unit_n;
  logic [OFF_W-1:0]  size_q, size_n;
  logic              unit_ok, base_ok;

  assign unit_ok = (wdata >= DATA_W'(UNIT_MIN)) && (wdata <= DATA_W'(UNIT_MAX));
  assign base_ok = (wdata[BASE_W-1:0] != BASE_RESV_A) && (wdata[BASE_W-1:0] != BASE_RESV_B);

  always_comb begin
    en_n   = en_q;
    err_n  = err_q;
    dep_n  = dep_q;
    base_n = base_q;
    unit_n = unit_q;
    size_n = size_q;
    if (wr) begin
      case (cfg_sel_e'(sel))
        SEL_CTRL: begin
          if (en_q) begin
            en_n = wdata[0];
          end else if (wdata[2:1] == DEPTH_BAD) begin
            err_n = 1'b1;
          end else begin
            en_n  = wdata[0];
            dep_n = wdata[2:1];
          end
        end
        SEL_BASE: begin
          if (en_q || !base_ok) err_n = 1'b1;
          else                  base_n = wdata[BASE_W-1:0];
        end
        SEL_LINE: begin
          if (en_q || !unit_ok) err_n = 1'b1;
          else                  unit_n = wdata[UNIT_W-1:0];
        end
        default: begin
          if (en_q) err_n = 1'b1;
          else      size_n = wdata[OFF_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      dep_q  <= DEPTH_RST;
      base_q <= BASE_RST;
      unit_q <= UNIT_W'(UNIT_MAX);
      size_q <= '1;
    end else if (wr) begin
      en_q   <= en_n;
      err_q  <= err_n;
      dep_q  <= dep_n;
      base_q <= base_n;
      unit_q <= unit_n;
      size_q <= size_n;
    end
  end

  assign en      = en_q;
  assign depth   = dep_q;
  assign base    = base_q;
  assign units   = unit_q;
  assign size_m1 = size_q;
  assign err     = err_q;
endmodule

// File: rtl/fbag_span.sv
module fbag_span #(
  parameter int UNIT_W = 7,
  localparam int WPL_W = UNIT_W + 1
) (
  input  logic [UNIT_W-1:0] units,
  input  logic [1:0]        depth,
  output logic [WPL_W-1:0]  wpl
);
  localparam int PROD_W = UNIT_W + 3;
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(units) << depth;
    wpl  = WPL_W'((prod + PROD_W'(1)) >> 1);
  end
endmodule

// File: rtl/fbag_walk.sv
module fbag_walk #(
  parameter int OFF_W = 15,
  parameter int WPL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fire,
  input  logic [WPL_W-1:0] wpl,
  input  logic [OFF_W-1:0] size_m1,
  output logic [OFF_W-1:0] off,
  output logic             line_end,
  output logic             frame_end
);
  logic [OFF_W-1:0] off_q, off_n;
  logic [WPL_W-1:0] wc_q, wc_n;
  logic             step;

  assign line_end  = en && (wc_q == wpl - WPL_W'(1));
  assign frame_end = en && (off_q == size_m1);
  assign step      = !en || fire;

  always_comb begin
    if (!en) begin
      off_n = '0;
      wc_n  = '0;
    end else begin
      off_n = frame_end ? '0 : off_q + OFF_W'(1);
      wc_n  = (frame_end || line_end) ? '0 : wc_q + WPL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      wc_q  <= '0;
    end else if (step) begin
      off_q <= off_n;
      wc_q  <= wc_n;
    end
  end

  assign off = off_q;
endmodule

// File: rtl/fbuf_addr_gen.sv
module fbuf_addr_gen
  import fbag_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 15,
  parameter int UNIT_W   = 7,
  parameter int UNIT_MIN = 2,
  parameter int UNIT_MAX = 64,
  localparam int WPL_W   = UNIT_W + 1,
  localparam int PAD_W   = ADDR_W - BASE_W - OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              cfg_err,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_line_end,
  output logic              req_frame_end
);
  logic              en;
  logic [1:0]        depth;
  logic [BASE_W-1:0] base;
  logic [UNIT_W-1:0] units;
  logic [OFF_W-1:0]  size_m1, off;
  logic [WPL_W-1:0]  wpl;

  fbag_cfg #(
    .DATA_W(DATA_W), .UNIT_W(UNIT_W), .OFF_W(OFF_W),
    .UNIT_MIN(UNIT_MIN), .UNIT_MAX(UNIT_MAX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .en(en), .depth(depth), .base(base), .units(units),
    .size_m1(size_m1), .err(cfg_err)
  );

  fbag_span #(.UNIT_W(UNIT_W)) u_span (
    .units(units), .depth(depth), .wpl(wpl)
  );

  fbag_walk #(.OFF_W(OFF_W), .WPL_W(WPL_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .en(en), .fire(en && req_ready),
    .wpl(wpl), .size_m1(size_m1), .off(off),
    .line_end(req_line_end), .frame_end(req_frame_end)
  );

  assign req_valid = en;
  assign req_addr  = {base, {PAD_W{1'b0}}, off, 2'b00};
endmodule

// File: rtl/fbuf_addr_gen_chk.sv
module fbuf_addr_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [1:0]        cfg_sel,
  input logic              cfg_err,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_line_end,
  input logic              req_frame_end
);
  localparam int LOW_W = ADDR_W - 4;

  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !cfg_wr |=>
      req_valid && $stable(req_addr) && $stable(req_line_end) && $stable(req_frame_end));

  a_r2_step_by_word: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_frame_end && !cfg_wr |=>
      req_addr == $past(req_addr) + ADDR_W'(4));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_frame_end && !cfg_wr |=>
      req_valid && (req_addr[LOW_W-1:0] == '0));

  a_r6_locked_region: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cfg_wr && (cfg_sel != 2'd0) |=>
      cfg_err && req_valid && (req_addr[ADDR_W-1:LOW_W] == $past(req_addr[ADDR_W-1:LOW_W])));

  a_r7_no_reserved_region: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[ADDR_W-1:LOW_W] != 4'h7) && (req_addr[ADDR_W-1:LOW_W] != 4'h8));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r4_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_line_end || req_frame_end) |-> req_valid);

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);
endmodule

bind fbuf_addr_gen fbuf_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_line_end(req_line_end), .req_frame_end(req_frame_end)
);

// File: tb/test_fbuf_addr_gen.sv
module test_fbuf_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        cfg_err, req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        req_line_end, req_frame_end;

  always #2.5 clk = ~clk;

  fbuf_addr_gen i_fbuf_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_err(cfg_err), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr),
    .req_line_end(req_line_end), .req_frame_end(req_frame_end)
  );

  int total = 0, bad = 0, popped = 0, cyc = 0;
  logic [33:0] sb_q[$];
  logic [3:0]  m_base;
  int          m_wpl, m_size, m_off, m_wc;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops and compares on every handshake
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R2 unexpected request", req_addr, 0);
      end else begin
        logic [33:0] e;
        e = sb_q.pop_front();
        chk({req_addr, req_line_end, req_frame_end} == e, "R2/R4/R5 request",
            {req_addr, req_line_end, req_frame_end}, e);
        popped++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    req_ready = 1'b0;
    cfg_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    m_base = 4'hC; m_wpl = 128; m_size = 32768;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic enable(input logic [1:0] dep);
    m_off = 0; m_wc = 0;
    wr(2'd0, {13'd0, dep, 1'b1});
  endtask

  // driver: predict n words, then drive ready until all are seen
  task automatic run(input int n, input int pat);
    int k;
    for (int i = 0; i < n; i++) begin
      bit le, fe;
      le = (m_wc == m_wpl - 1);
      fe = (m_off == m_size - 1);
      sb_q.push_back({m_base, 11'd0, m_off[14:0], 2'b00, le, fe});
      if (fe) begin m_off = 0; m_wc = 0; end
      else begin m_off++; m_wc = le ? 0 : m_wc + 1; end
    end
    k = 0;
    popped = 0;
    forever begin
      @(posedge clk); #1;
      if (popped >= n) break;
      req_ready = (pat == 0) ? 1'b1 : ((k % pat) != 0);
      k++;
    end
    req_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] held;
    do_reset();
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 valid after reset", req_valid, 0);
    chk(cfg_err == 1'b0, "R1 err after reset", cfg_err, 0);

    // R1/R2/R4: defaults, 128 words per line
    enable(2'd2);
    run(300, 0);

    // R8: disable, valid drops
    wr(2'd0, 16'd0);
    @(negedge clk);
    chk(req_valid == 1'b0, "R8 valid after disable", req_valid, 0);

    // R4/R5: 48 px at 2 bpp -> 3 words/line, 10-word buffer
    wr(2'd1, 16'h3); m_base = 4'h3;
    wr(2'd2, 16'd3); m_wpl = 3;
    wr(2'd3, 16'd9); m_size = 10;
    enable(2'd1);
    run(25, 3);

    // R3: stall keeps the request
    @(negedge clk); held = req_addr;
    repeat (4) @(negedge clk);
    chk(req_valid && req_addr == held, "R3 stall holds address", req_addr, held);

    // R6: locked while enabled
    wr(2'd1, 16'h2);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R6 err on locked write", cfg_err, 1);
    chk(req_addr[31:28] == 4'h3, "R6 region unchanged", req_addr[31:28], 3);
    wr(2'd2, 16'd8);
    wr(2'd0, 16'h0001);   // depth field 0 ignored while enabled
    run(12, 2);           // continues with 3 words/line, region 3

    // R8: re-enable restarts at zero; R9 sticky
    wr(2'd0, 16'd0);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R9 err sticky", cfg_err, 1);
    // R4 rounding: 80 px at 1 bpp -> ceil(5/2) = 3 words, 7-word buffer
    wr(2'd2, 16'd5); m_wpl = 3;
    wr(2'd3, 16'd6); m_size = 7;
    enable(2'd0);
    run(16, 4);

    // R7: rejections, one per reset
    do_reset();
    wr(2'd1, 16'h7);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R7 region 7 rejected", cfg_err, 1);
    enable(2'd2);
    run(3, 0);
    do_reset();
    wr(2'd1, 16'h8);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R7 region 8 rejected", cfg_err, 1);
    do_reset();
    wr(2'd2, 16'd1);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R7 line 1 rejected", cfg_err, 1);
    do_reset();
    wr(2'd2, 16'd65);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R7 line 65 rejected", cfg_err, 1);
    do_reset();
    wr(2'd0, 16'b111);
    @(negedge clk);
    chk(cfg_err == 1'b1 && req_valid == 1'b0, "R7 depth 3 rejected", {cfg_err, req_valid}, 2'b10);
    do_reset();
    wr(2'd1, 16'h6); m_base = 4'h6;
    wr(2'd2, 16'd64);
    wr(2'd3, 16'd4); m_size = 5;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R7 region 6 and line 64 accepted", cfg_err, 0);
    enable(2'd2);
    run(8, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule